// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-facing half of a 1 KiB byte-addressed non-volatile store that answers as a target on a two-wire I2C bus. A fast system clock oversamples the bus clock and data lines. The block finds START and STOP conditions, decides whether a select byte is meant for it, and acknowledges. It then either collects a word address and data bytes for the write path, or streams stored bytes back to the bus controller. The data line is driven only as an open-drain pull-down enable.

Received data bytes go to an external write path as single-cycle strobes that carry the target address. A STOP after at least one data byte raises a commit request. The write path answers with a busy level for as long as its internal programming cycle lasts. While busy is high, the block stays silent on the bus, so a controller can poll for the end of the cycle by sending select bytes until one is acknowledged. Stored data comes back through a read-address output and a read-data input that follows the address with one cycle of latency, as an inferred block RAM does.

Top module: `twi_mem_target`

## Requirements
- R1: START is a falling data line while the clock line is high. STOP is a rising data line while the clock line is high. Before the first START, clock and data activity causes no acknowledge and no write strobe.
- R2: A select byte is accepted only if bits 7..4 are 1010 and bit 3 equals `pin_sel`. Any other select byte gets no acknowledge, and the target ignores the bus until the next START.
- R3: The target acknowledges an accepted select byte, the word address byte and every written data byte by pulling the data line low during the ninth clock.
- R4: In a write select byte, bits 2..1 become address bits 9..8. The word address byte that follows supplies bits 7..0. Bit 0 of the select byte is 1 for a read and 0 for a write.
- R5: Each received data byte gives one `wr_byte_valid` pulse carrying its address and value. `wr_first` is high on the first data byte after the word address. After each data byte, address bits 3..0 step up and wrap inside the 16-byte page. Bits 9..4 do not change.
- R6: `wr_commit` pulses for one cycle after a STOP, and only if at least one data byte was received since the last START. A repeated START discards the pending write without a commit.
- R7: A read sends 8 bits, most significant bit first. The target releases the data line on the ninth clock. It sends the next byte while the controller acknowledges, and stops sending after a not-acknowledge.
- R8: The read address steps by one after each byte across all 10 bits, and wraps from 0x3FF to 0x000.
- R9: A read select with no address phase reads from the location after the last byte written or read. A write of the address only, then a repeated START and a read select, reads from that address.
- R10: While `wr_busy` is high, no select byte is acknowledged and `sda_oe` stays low.
- R11: Incoming bits are taken at the rising clock edge. `sda_oe` changes only while the synchronized clock line is low, after a falling edge.
- R12: A repeated START in the middle of a byte drops that byte with no write strobe, and the target returns to select-byte reception.
- R13: After reset, `sda_oe`, `wr_byte_valid` and `wr_commit` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pin_sel | input | 1 | Strap value that select bit 3 must equal |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_byte_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_first | output | 1 | High with the first data byte of a write |
| wr_addr | output | 10 | Address of the strobed data byte |
| wr_data | output | 8 | Value of the strobed data byte |
| wr_commit | output | 1 | One-cycle request to program the collected bytes |
| wr_busy | input | 1 | Write path is in its programming cycle |
| rd_addr | output | 10 | Current address pointer toward the store |
| rd_data | input | 8 | Stored byte at `rd_addr`, one cycle late |

## Verification
If the bit counter or the state register is wrong, the acknowledge lands on the wrong clock. The controller then sees a not-acknowledge, or corrupted bits in the next byte, within the same nine-clock frame. A bad address pointer only shows later, when the wrong byte comes back on a following read. For that reason the bench reads every write back, reads across the page and array boundaries, and checks the continuation of a current-address read. If commit handling goes wrong, the busy window appears in the wrong place, and the polling select after a STOP shows it at once.

// File: rtl/twi_pkg.sv
package twi_pkg;

  // protocol phase of the target
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_RX,     // shifting in a byte
    ST_ACK,    // holding the line low on the ninth clock
    ST_TX,     // shifting out a byte
    ST_MACK    // waiting for the controller's acknowledge
  } twi_state_e;

  // meaning of the byte being received
  typedef enum logic [1:0] {
    BK_SEL,
    BK_WADR,
    BK_WDAT
  } byte_kind_e;

  localparam logic [3:0] DEV_CODE_DEFAULT = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [1:0] raw;
  logic [1:0] synced;
  logic [1:0] prev;

  assign raw = {scl_i, sda_i};

  // one synchronizer chain per bus line, idle level high
  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[l]};
    end
    assign synced[l] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 2'b11;
    else     prev <= synced;
  end

  assign scl_s    = synced[1];
  assign sda_s    = synced[0];
  assign scl_rise = synced[1] & ~prev[1];
  assign scl_fall = ~synced[1] & prev[1];
  assign start_ev = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_ev  = synced[1] & prev[1] & ~prev[0] & synced[0];

endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_page,
  input  logic              step_all,
  output logic [ADDR_W-1:0] ptr
);

  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);

  logic [ADDR_W-1:0] page_next;

  // page stepping keeps the upper bits unless the page spans the array
  if (PAGE_W < ADDR_W) begin : g_paged
    assign page_next = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + P_ONE};
  end else begin : g_flat
    assign page_next = ptr + A_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)            ptr <= '0;
    else if (load)      ptr <= load_val;
    else if (step_page) ptr <= page_next;
    else if (step_all)  ptr <= ptr + A_ONE;
  end

endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
  import twi_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter logic [3:0] DEV_CODE = DEV_CODE_DEFAULT,
  // ADDR_W is 9 or 10: address bits above 7 take the low select bits
  localparam int        HI_W     = ADDR_W - 8,
  localparam int        PIN_W    = 3 - HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [PIN_W-1:0]  pin_sel,
  input  logic              wr_busy,
  input  logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] ptr,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] ptr_val,
  output logic              ptr_step_page,
  output logic              ptr_step_all,
  output logic              sda_oe,
  output logic              wr_byte_valid,
  output logic              wr_first,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);

  twi_state_e      st;
  byte_kind_e      kind;
  logic [2:0]      cnt;
  logic            full;
  logic [7:0]      sh;
  logic            rw;
  logic [HI_W-1:0] pend_hi;
  logic            wrote;
  logic            first_pend;
  logic            mack;
  logic            sel_hit;

  assign sel_hit = (sh[7:4] == DEV_CODE) && (sh[3 -: PIN_W] == pin_sel) && !wr_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      kind          <= BK_SEL;
      cnt           <= '0;
      full          <= 1'b0;
      sh            <= '0;
      rw            <= 1'b0;
      pend_hi       <= '0;
      wrote         <= 1'b0;
      first_pend    <= 1'b0;
      mack          <= 1'b0;
      sda_oe        <= 1'b0;
      wr_byte_valid <= 1'b0;
      wr_first      <= 1'b0;
      wr_addr       <= '0;
      wr_data       <= '0;
      wr_commit     <= 1'b0;
      ptr_load      <= 1'b0;
      ptr_val       <= '0;
      ptr_step_page <= 1'b0;
      ptr_step_all  <= 1'b0;
    end else begin
      wr_byte_valid <= 1'b0;
      wr_commit     <= 1'b0;
      ptr_load      <= 1'b0;
      ptr_step_page <= 1'b0;
      ptr_step_all  <= 1'b0;
      if (start_ev) begin
        // any START, repeated or not, restarts select reception
        st     <= ST_RX;
        kind   <= BK_SEL;
        cnt    <= '0;
        full   <= 1'b0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_ev) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        wr_commit <= wrote;
        wrote     <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              case (kind)
                BK_SEL: begin
                  if (sel_hit) begin
                    sda_oe <= 1'b1;
                    st     <= ST_ACK;
                    rw     <= sh[0];
                    if (!sh[0]) pend_hi <= sh[HI_W:1];
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                BK_WADR: begin
                  ptr_load <= 1'b1;
                  ptr_val  <= {pend_hi, sh};
                  sda_oe   <= 1'b1;
                  st       <= ST_ACK;
                end
                default: begin
                  wr_byte_valid <= 1'b1;
                  wr_first      <= first_pend;
                  first_pend    <= 1'b0;
                  wr_addr       <= ptr;
                  wr_data       <= sh;
                  ptr_step_page <= 1'b1;
                  wrote         <= 1'b1;
                  sda_oe        <= 1'b1;
                  st            <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == BK_SEL && rw) begin
                sh           <= rd_data;
                sda_oe       <= ~rd_data[7];
                ptr_step_all <= 1'b1;
                st           <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                if (kind == BK_SEL) begin
                  kind <= BK_WADR;
                end else if (kind == BK_WADR) begin
                  kind       <= BK_WDAT;
                  first_pend <= 1'b1;
                end
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                cnt    <= cnt + 3'd1;
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sh           <= rd_data;
                sda_oe       <= ~rd_data[7];
                cnt          <= '0;
                ptr_step_all <= 1'b1;
                st           <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
  import twi_pkg::*;
#(
  parameter int         ADDR_W      = 10,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = DEV_CODE_DEFAULT,
  localparam int        HI_W        = ADDR_W - 8,
  localparam int        PIN_W       = 3 - HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [PIN_W-1:0]  pin_sel,
  output logic              sda_oe,
  output logic              wr_byte_valid,
  output logic              wr_first,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  input  logic              wr_busy,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);

  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_ev;
  logic              stop_ev;
  logic              ptr_load;
  logic [ADDR_W-1:0] ptr_val;
  logic              ptr_step_page;
  logic              ptr_step_all;
  logic [ADDR_W-1:0] ptr;

  twi_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twi_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ptr_i (
    .clk       (clk),
    .rst       (rst),
    .load      (ptr_load),
    .load_val  (ptr_val),
    .step_page (ptr_step_page),
    .step_all  (ptr_step_all),
    .ptr       (ptr)
  );

  twi_target_fsm #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) fsm_i (
    .clk           (clk),
    .rst           (rst),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .sda_s         (sda_s),
    .pin_sel       (pin_sel),
    .wr_busy       (wr_busy),
    .rd_data       (rd_data),
    .ptr           (ptr),
    .ptr_load      (ptr_load),
    .ptr_val       (ptr_val),
    .ptr_step_page (ptr_step_page),
    .ptr_step_all  (ptr_step_all),
    .sda_oe        (sda_oe),
    .wr_byte_valid (wr_byte_valid),
    .wr_first      (wr_first),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_commit     (wr_commit)
  );

  assign rd_addr = ptr;

endmodule

// File: rtl/twi_mem_target_chk.sv
module twi_mem_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic wr_busy,
  input logic wr_byte_valid,
  input logic wr_commit
);

  // R11
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R10
  busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
    wr_busy |-> !sda_oe);

  // R6
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(stop_ev));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_byte_valid |=> !wr_byte_valid);

  // R6
  strobe_commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_byte_valid, wr_commit}));

  // R12
  restart_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_oe);

endmodule

bind twi_mem_target twi_mem_target_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .scl_s         (scl_s),
  .start_ev      (start_ev),
  .stop_ev       (stop_ev),
  .sda_oe        (sda_oe),
  .wr_busy       (wr_busy),
  .wr_byte_valid (wr_byte_valid),
  .wr_commit     (wr_commit)
);

// File: tb/twi_mem_target_tb_top.sv
module twi_mem_target_tb_top;

  localparam int Q        = 8;
  localparam int BUSY_CYC = 2000;
  localparam logic PIN    = 1'b1;

  // {op(1=read), addr[9:0], data/expected[7:0]}
  localparam logic [18:0] VEC [12] = '{
    {1'b0, 10'h005, 8'h11}, {1'b0, 10'h105, 8'h22},
    {1'b0, 10'h205, 8'h33}, {1'b0, 10'h305, 8'h44},
    {1'b0, 10'h3FF, 8'hA5}, {1'b0, 10'h000, 8'h5A},
    {1'b0, 10'h001, 8'hC3}, {1'b0, 10'h002, 8'h3C},
    {1'b1, 10'h005, 8'h11}, {1'b1, 10'h105, 8'h22},
    {1'b1, 10'h205, 8'h33}, {1'b1, 10'h305, 8'h44}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_oe, wr_byte_valid, wr_first, wr_commit, wr_busy;
  logic [9:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int nchk = 0, nerr = 0;
  int n_valid = 0, n_first = 0, n_commit = 0, oe_hits = 0, oe_bad = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  logic [7:0] mem [1024];
  logic [7:0] exp_mem [1024];
  logic [7:0] stg_d [16];
  logic [15:0] stg_v;
  logic [9:0] stg_base;
  int busy_cnt;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;
  assign wr_busy = (busy_cnt != 0);

  twi_mem_target dut_i (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .pin_sel(PIN),
    .sda_oe(sda_oe), .wr_byte_valid(wr_byte_valid), .wr_first(wr_first),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .wr_busy(wr_busy), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial begin
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
    stg_v = '0; stg_base = '0; busy_cnt = 0;
  end

  // store and write-path model
  always @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (!rst) begin
      if (wr_byte_valid) begin
        stg_v = (wr_first ? 16'h0 : stg_v) | (16'h1 << wr_addr[3:0]);
        stg_d[wr_addr[3:0]] = wr_data;
        stg_base = wr_addr;
        n_valid++;
        if (wr_first) n_first++;
      end
      if (wr_commit) begin
        n_commit++;
        busy_cnt = BUSY_CYC;
      end else if (busy_cnt != 0) begin
        if (busy_cnt == 1)
          for (int i = 0; i < 16; i++)
            if (stg_v[i]) mem[{stg_base[9:4], i[3:0]}] = stg_d[i];
        busy_cnt--;
      end
      if (sda_oe) oe_hits++;
      if (sda_oe != oe_prev && m_scl) oe_bad++;
      oe_prev = sda_oe;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cw(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; cw(Q); m_scl = 1'b1; cw(2*Q);
    m_sda = 1'b0; cw(2*Q); m_scl = 1'b0; cw(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cw(Q); m_scl = 1'b1; cw(2*Q); m_sda = 1'b1; cw(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; cw(Q); m_scl = 1'b1; cw(2*Q); m_scl = 1'b0; cw(Q);
    end
    m_sda = 1'b1; cw(Q); m_scl = 1'b1; cw(Q);
    ack = !sda_line; cw(Q); m_scl = 1'b0; cw(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; cw(Q); m_scl = 1'b1; cw(Q);
      d[i] = sda_line; cw(Q); m_scl = 1'b0; cw(Q);
    end
    m_sda = !mack; cw(Q); m_scl = 1'b1; cw(2*Q); m_scl = 1'b0; cw(Q);
  endtask

  function automatic logic [7:0] sel(input logic [1:0] hi, input logic rd);
    return {4'b1010, PIN, hi, rd};
  endfunction

  task automatic poll_ready(output int polls);
    logic a;
    polls = 0;
    for (int k = 0; k < 40; k++) begin
      bus_start(); send_byte(sel(2'b00, 1'b0), a); bus_stop();
      if (a) break;
      polls++;
    end
  endtask

  task automatic write_byte(input logic [9:0] ad, input logic [7:0] d);
    logic a; int p;
    bus_start();
    send_byte(sel(ad[9:8], 1'b0), a); chk("R3 select ack", a, 1);
    send_byte(ad[7:0], a);            chk("R3 address ack", a, 1);
    send_byte(d, a);                  chk("R3 data ack", a, 1);
    bus_stop();
    exp_mem[ad] = d;
    poll_ready(p);
  endtask

  task automatic rand_read(input logic [9:0] ad, input int n, output logic [7:0] d0);
    logic a; logic [7:0] d;
    bus_start();
    send_byte(sel(ad[9:8], 1'b0), a); chk("R9 dummy write ack", a, 1);
    send_byte(ad[7:0], a);            chk("R4 address ack", a, 1);
    bus_start();
    send_byte(sel(2'b00, 1'b1), a);   chk("R9 read select ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n-1, d);
      if (k == 0) d0 = d;
      chk("R8 sequential data", d, exp_mem[(ad + 10'(k)) & 10'h3FF]);
    end
    bus_stop();
  endtask

  initial begin
    logic a; logic [7:0] d; int h0, v0, c0, p;
    cw(5); rst = 1'b0; cw(3);
    // R13 reset state
    chk("R13 sda_oe", sda_oe, 0);
    chk("R13 valid", wr_byte_valid, 0);
    chk("R13 commit", wr_commit, 0);

    // R1 bus activity without START is ignored
    h0 = oe_hits;
    for (int i = 8; i >= 0; i--) begin
      m_scl = 1'b0; cw(Q);
      m_sda = (i == 0) ? 1'b0 : sel(2'b00, 1'b0)[i-1]; cw(Q);
      m_scl = 1'b1; cw(2*Q);
    end
    m_scl = 1'b0; cw(Q); m_sda = 1'b1; cw(Q); m_scl = 1'b1; cw(2*Q);
    chk("R1 no ack without start", oe_hits - h0, 0);
    chk("R1 no strobe without start", n_valid, 0);

    // R2 wrong device code and wrong strap bit
    h0 = oe_hits;
    bus_start(); send_byte(8'b1011_1000, a); bus_stop();
    chk("R2 wrong code nack", a, 0);
    bus_start(); send_byte({4'b1010, ~PIN, 3'b000}, a); bus_stop();
    chk("R2 wrong pin nack", a, 0);
    chk("R2 line untouched", oe_hits - h0, 0);

    // vector table: writes then random reads (R4 high bits in select)
    foreach (VEC[i]) begin
      if (VEC[i][18]) begin
        rand_read(VEC[i][17:8], 1, d);
        chk("R4 table read", d, VEC[i][7:0]);
      end else begin
        write_byte(VEC[i][17:8], VEC[i][7:0]);
      end
    end

    // R8 wrap at array end, R7 multi-byte read
    rand_read(10'h3FF, 3, d);
    chk("R8 first byte at top", d, 8'hA5);
    // R9 current-address read continues at 0x002
    bus_start(); send_byte(sel(2'b11, 1'b1), a);
    chk("R9 current read ack", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R9 current read data", d, 8'h3C);

    // R5 page write of 18 bytes from offset 14, wrapping inside the page
    v0 = n_valid; h0 = n_first; c0 = n_commit;
    bus_start();
    send_byte(sel(2'b01, 1'b0), a);
    send_byte(8'h3E, a);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'h40 + 8'(k), a);
      chk("R3 page data ack", a, 1);
      exp_mem[10'h130 | 10'((14 + k) & 15)] = 8'h40 + 8'(k);
    end
    bus_stop();
    cw(4);
    chk("R5 strobe count", n_valid - v0, 18);
    chk("R5 first count", n_first - h0, 1);
    chk("R6 commit count", n_commit - c0, 1);

    // R10 busy: select not acknowledged, line not driven
    h0 = oe_hits;
    bus_start(); send_byte(sel(2'b00, 1'b0), a); bus_stop();
    chk("R10 busy nack", a, 0);
    chk("R10 busy line free", oe_hits - h0, 0);
    c0 = n_commit;
    poll_ready(p);
    chk("R10 poll ends", p < 40, 1);
    chk("R6 no commit without data", n_commit - c0, 0);
    rand_read(10'h130, 16, d);
    chk("R5 page offset 0", d, 8'h42);

    // R6 repeated START after data: no commit
    c0 = n_commit; v0 = n_valid;
    bus_start();
    send_byte(sel(2'b00, 1'b0), a); send_byte(8'h50, a); send_byte(8'h77, a);
    chk("R5 strobe for data", n_valid - v0, 1);
    bus_start();
    send_byte(sel(2'b00, 1'b1), a); chk("R9 read after restart ack", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R5 page step to 0x051", d, exp_mem[10'h051]);
    cw(10);
    chk("R6 restart drops commit", n_commit - c0, 0);
    chk("R6 not busy", wr_busy, 0);
    rand_read(10'h050, 1, d);
    chk("R6 location unchanged", d, 8'hFF);

    // R12 repeated START mid-byte
    v0 = n_valid;
    bus_start();
    send_byte(sel(2'b00, 1'b0), a); send_byte(8'h60, a);
    for (int i = 7; i >= 4; i--) begin
      m_sda = 8'hAB >> i; cw(Q); m_scl = 1'b1; cw(2*Q); m_scl = 1'b0; cw(Q);
    end
    bus_start();
    send_byte(sel(2'b00, 1'b1), a);
    chk("R12 select after abort ack", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R12 read from loaded address", d, exp_mem[10'h060]);
    chk("R12 no strobe for partial byte", n_valid - v0, 0);

    chk("R11 oe changes with clock low", oe_bad, 0);
    chk("R7 line released at end", sda_oe, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R13 watchdog act=hung exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule